// File: doc/BRIEF.md
# Self-Framing Serial Segment Latch

This block receives a display word over a two-wire serial link (a clock and a data line) and presents it as a bank of parallel segment-on flags. Both serial lines are brought into the system clock domain through two-flop synchronizers. The block then finds the edges of the serial clock by comparing successive samples. Framing needs no load strobe. Each word opens with a marker bit of 1, and the word is complete when that marker has moved past every payload position. At that point the payload is copied into the output latches. On the following low phase the shift chain clears itself and is ready for the next word.

The input stage that holds the data line while the serial clock is low is never cleared. A new marker can therefore follow the last payload bit with no idle clocks between words. If a word is cut short, nothing is loaded. The bits already shifted in are kept, and the word completes when the remaining clocks arrive. An optional variant turns the last output into an active-high enable input. Serial clock edges are counted only while that input is high.

Top module: `seg_serial_latch`

## Requirements
- R1: While rst_ni is low, every bit of seg_o is 0 and the shift chain is empty.
- R2: A word is one marker bit of 1 followed by NUM_DATA (default 35) payload bits, one per rising edge of sclk_i. seg_o takes the new payload after the NUM_DATA+1-th rising edge, at most 5 system clocks after that edge reaches sclk_i.
- R3: The first payload bit after the marker drives seg_o[0], and payload bit k drives seg_o[k-1]. A 1 means segment on.
- R4: After fewer than NUM_DATA+1 rising edges, seg_o is unchanged and the bits received so far are kept. Further edges complete the same word.
- R5: Words may follow each other with no idle serial clocks, and each of them loads correctly.
- R6: Any 0 bits clocked in before a marker have no effect on seg_o, and the word that follows still loads correctly.
- R7: The data bit is the level of sdata_i while sclk_i is low, just before the rising edge. Changes of sdata_i while sclk_i is high or idle have no effect.
- R8: With HAS_DEN=1, seg_o has NUM_DATA-1 bits and the last payload bit is dropped. Rising edges of sclk_i that occur while den_i is low are ignored.
- R9: A load replaces every output bit, so a bit that was 1 becomes 0 when the new word carries 0 in its position, and seg_o holds its value between loads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 8 times the serial clock rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock, asynchronous to clk_i |
| sdata_i | input | 1 | Serial data, sampled before each serial rising edge |
| den_i | input | 1 | Active-high data enable, used only when HAS_DEN=1 |
| seg_o | output | NUM_DATA-HAS_DEN | Latched segment-on flags, bit 0 is the first payload bit |

## Verification
The assertions assume that each level of sclk_i lasts several system clocks. This keeps a rising and a falling edge from landing on the same synchronized sample. They also assume that sdata_i and den_i settle well before the serial rising edge, so their synchronized copies are valid when the edge is detected. The stimulus holds every serial half-period for 16 system clocks and changes data and enable only at the start of a low phase. The one exception is the deliberate glitching of the data line, which is confined to high phases and idle periods.

// File: rtl/seg_pkg.sv
package seg_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
    logic high;
  } sclk_ev_t;
endpackage

// File: rtl/seg_sync.sv
module seg_sync #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/seg_edge.sv
module seg_edge
  import seg_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sclk_s_i,
  output sclk_ev_t ev_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sclk_s_i;
  end

  assign ev_o.rise = sclk_s_i & ~prev_q;
  assign ev_o.fall = ~sclk_s_i & prev_q;
  assign ev_o.high = sclk_s_i;
endmodule

// File: rtl/seg_shift.sv
module seg_shift
  import seg_pkg::*;
#(
  parameter int unsigned NUM_DATA = 35
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  sclk_ev_t            ev_i,
  input  logic                sd_s_i,
  input  logic                en_i,
  output logic [NUM_DATA-1:0] data_o,
  output logic                load_o
);
  localparam int unsigned CHAIN_W = NUM_DATA + 1;

  logic               cap_q;    // input stage, never cleared by frame end
  logic [CHAIN_W-1:0] chain_q;
  logic               done;

  assign done = chain_q[CHAIN_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cap_q <= 1'b0;
    else if (!ev_i.high)  cap_q <= sd_s_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    chain_q <= '0;
    else if (ev_i.rise && en_i)     chain_q <= {chain_q[CHAIN_W-2:0], cap_q};
    else if (ev_i.fall && done)     chain_q <= '0;
  end

  // first payload bit sits just below the marker
  for (genvar i = 0; i < NUM_DATA; i++) begin : g_order
    assign data_o[i] = chain_q[NUM_DATA-1-i];
  end

  assign load_o = done & ev_i.high;

  a_r5_clear_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i.fall && done) |=> (chain_q == '0));
  a_r4_keep_partial: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i.fall && !done) |=> $stable(chain_q));
  a_r7_cap_frozen_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i.high |=> $stable(cap_q));
  a_r8_gated_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !ev_i.fall) |=> $stable(chain_q));
endmodule

// File: rtl/seg_latch.sv
module seg_latch #(
  parameter int unsigned NUM_OUT = 35
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [NUM_OUT-1:0] data_i,
  output logic [NUM_OUT-1:0] seg_o
);
  logic [NUM_OUT-1:0] seg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     seg_q <= '0;
    else if (load_i) seg_q <= data_i;
  end

  assign seg_o = seg_q;

  a_r9_hold_between_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(seg_q));
endmodule

// File: rtl/seg_serial_latch.sv
module seg_serial_latch
  import seg_pkg::*;
#(
  parameter int unsigned NUM_DATA = 35,
  parameter int unsigned HAS_DEN  = 0
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        sclk_i,
  input  logic                        sdata_i,
  input  logic                        den_i,
  output logic [NUM_DATA-HAS_DEN-1:0] seg_o
);
  localparam int unsigned NUM_OUT = NUM_DATA - HAS_DEN;

  logic                sclk_s, sd_s, den_s, en;
  sclk_ev_t            ev;
  logic [NUM_DATA-1:0] data;
  logic                load;

  seg_sync #(.WIDTH(3)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sclk_i, sdata_i, den_i}),
    .q_o    ({sclk_s, sd_s, den_s})
  );

  if (HAS_DEN != 0) begin : g_den
    assign en = den_s;
  end else begin : g_no_den
    assign en = 1'b1 | den_s;
  end

  seg_edge u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sclk_s_i (sclk_s),
    .ev_o     (ev)
  );

  seg_shift #(.NUM_DATA(NUM_DATA)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ev_i   (ev),
    .sd_s_i (sd_s),
    .en_i   (en),
    .data_o (data),
    .load_o (load)
  );

  seg_latch #(.NUM_OUT(NUM_OUT)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .data_i (data[NUM_OUT-1:0]),
    .seg_o  (seg_o)
  );

  a_r1_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (seg_o == '0));
endmodule

// File: tb/sim_seg_serial_latch.sv
module sim_seg_serial_latch;
  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, sdat = 1'b0, den = 1'b1;
  logic [34:0] seg0;
  logic [33:0] seg1;

  always #2.5 clk = ~clk;

  seg_serial_latch #(.NUM_DATA(35), .HAS_DEN(0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdata_i(sdat), .den_i(den), .seg_o(seg0));
  seg_serial_latch #(.NUM_DATA(35), .HAS_DEN(1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdata_i(sdat), .den_i(den), .seg_o(seg1));

  typedef struct {
    logic [34:0] e0;
    bit          c0;
    logic [33:0] e1;
    bit          c1;
    string       tag;
  } item_t;

  item_t sbq[$];
  event  chk_ev;
  int    n_chk = 0, n_fail = 0;
  logic [34:0] lat0 = '0;
  logic [33:0] lat1 = '0;

  // monitor: pop expected items and compare with the outputs
  initial begin
    item_t it;
    forever begin
      @(chk_ev);
      while (sbq.size() > 0) begin
        it = sbq.pop_front();
        if (it.c0) begin
          n_chk++;
          if (seg0 !== it.e0) begin
            n_fail++;
            $display("FAIL %s u0 actual=%h expected=%h", it.tag, seg0, it.e0);
          end
        end
        if (it.c1) begin
          n_chk++;
          if (seg1 !== it.e1) begin
            n_fail++;
            $display("FAIL %s u1 actual=%h expected=%h", it.tag, seg1, it.e1);
          end
        end
      end
    end
  end

  task automatic expect_out(input logic [34:0] e0, input bit c0,
                            input logic [33:0] e1, input bit c1, input string tag);
    item_t it;
    it.e0 = e0; it.c0 = c0; it.e1 = e1; it.c1 = c1; it.tag = tag;
    sbq.push_back(it);
    repeat (4) @(negedge clk);
    ->chk_ev;
    @(negedge clk);
  endtask

  task automatic sbit(input logic b, input bit glitch);
    sdat = b;
    repeat (16) @(negedge clk);
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    if (glitch) sdat = ~b;
    repeat (12) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic frame(input logic [34:0] d, input bit glitch);
    sbit(1'b1, glitch);
    for (int i = 0; i < 35; i++) sbit(d[i], glitch);
  endtask

  task automatic frame_chk(input logic [34:0] d, input string tag);
    frame(d, 1'b0);
    lat0 = d; lat1 = d[33:0];
    expect_out(lat0, 1'b1, lat1, 1'b1, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [34:0] p;
    repeat (5) @(negedge clk);
    expect_out('0, 1'b1, '0, 1'b1, "R1 reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    frame_chk(35'h0_0000_0001, "R3 first bit to output 0");
    frame_chk(35'h4_0000_0000, "R8 last bit dropped / R3 last bit");
    frame_chk(35'h2_AAAA_AAAA, "R2 pattern a");
    frame_chk(35'h5_5555_5555, "R2 pattern b");
    frame_chk(35'h7_FFFF_FFFF, "R9 all on");
    frame_chk(35'h0_0F0F_0F0F, "R9 overwrite with zeros");

    // R4: partial word then resume
    p = 35'h3_1234_5678;
    sbit(1'b1, 1'b0);
    for (int i = 0; i < 19; i++) sbit(p[i], 1'b0);
    expect_out(lat0, 1'b1, lat1, 1'b1, "R4 partial holds");
    for (int i = 19; i < 35; i++) sbit(p[i], 1'b0);
    lat0 = p; lat1 = p[33:0];
    expect_out(lat0, 1'b1, lat1, 1'b1, "R4 resumed word loads");

    // R5: back-to-back words
    frame(35'h1_1111_1111, 1'b0);
    frame_chk(35'h6_DEAD_BEEF, "R5 back to back");

    // R6: leading zeros
    for (int i = 0; i < 6; i++) sbit(1'b0, 1'b0);
    expect_out(lat0, 1'b1, lat1, 1'b1, "R6 zeros no effect");
    frame_chk(35'h0_CAFE_F00D, "R6 word after zeros");

    // R7: data changes while clock high or idle
    p = 35'h5_A5A5_A5A5;
    frame(p, 1'b1);
    lat0 = p; lat1 = p[33:0];
    expect_out(lat0, 1'b1, lat1, 1'b1, "R7 glitch while high");
    for (int i = 0; i < 10; i++) begin
      sdat = ~sdat;
      repeat (3) @(negedge clk);
    end
    expect_out(lat0, 1'b1, lat1, 1'b1, "R7 idle data toggles");

    // R8: edges ignored while enable low (u1 only after this)
    sdat = 1'b0;
    den = 1'b0;
    repeat (10) @(negedge clk);
    for (int i = 0; i < 7; i++) sbit(1'b1, 1'b0);
    expect_out(lat0, 1'b1, lat1, 1'b1, "R8 enable low partial");
    den = 1'b1;
    repeat (10) @(negedge clk);
    p = 35'h2_0F1E_2D3C;
    frame(p, 1'b0);
    lat1 = p[33:0];
    expect_out('0, 1'b0, lat1, 1'b1, "R8 edges with enable low ignored");

    repeat (10) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule